// File: doc/BRIEF.md
# Counting Membership Filter with Removal

This block answers set-membership questions for fixed-width keys. A key may be added, removed or tested. Each of NHASH positions in an NPOS-entry table is derived from the key by a CRC. Every position has a small saturating counter and a single presence bit. Updates walk the NHASH positions one per cycle, doing a read-modify-write on the counter at each. The presence bit flips only when its counter moves between zero and one. A test reads nothing but the presence bits, so it may report false positives but never false negatives.

A parameter sets the counter width. It can be 2, 3 or 4 bits, or 0 for a small table that keeps only the presence bits. The block counts the presence bits that are set. It raises a flag once that count passes a percentage of the table, which tells the owner to rebuild the table elsewhere.

Top module: `cbf_filter`

## Requirements
- R1: After reset every counter and presence bit is 0. `cmd_ready` is 1 and `res_valid`, `occ_count`, `rebuild_flag` and `underflow_err` are 0. Every key tests absent.
- R2: Hash j (0 to NHASH-1) starts a 16-bit register at 16'hFFFF XOR the low 16 bits of j*16'h2F35. Key bits are fed most significant first: fb = reg[15]^bit, the register shifts left by one, and it is XORed with 16'h1021 when fb is 1. The position is the low log2(NPOS) bits of the result.
- R3: A test is a command with `cmd_op` 0 or 3. In the cycle after it is accepted, `res_valid` is 1 for one cycle and `res_hit` is 1 exactly when all NHASH presence bits of the key are 1.
- R4: An add (`cmd_op` 1) raises the counter at each hashed position by one, in position order. A position that appears twice is raised twice. A presence bit is set when its counter leaves 0.
- R5: A removal (`cmd_op` 2) lowers the counter at each hashed position by one. A presence bit clears when its counter goes from 1 to 0.
- R6: A counter at its maximum, 2^CNT_W-1, stays there on an add and is never lowered again. A key that saturated its counters keeps testing present after any number of removals.
- R7: A removal that finds a counter at 0 leaves that position unchanged. It sets `underflow_err`, which stays 1 until reset.
- R8: Once an add or removal is accepted, `cmd_ready` is 0 for exactly NHASH cycles and `res_valid` stays 0. A test presented meanwhile waits, and its answer reflects the completed update.
- R9: `occ_count` equals the number of presence bits at 1. `rebuild_flag` is 1 exactly when occ_count*100 > NPOS*OCC_PCT.
- R10: With CNT_W = 0 there are no counters. An add sets the bit at each position. A removal clears a set bit, or sets `underflow_err` if the bit was already clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0/3 test, 1 add, 2 remove |
| cmd_key | input | KEY_W | Key of the command |
| res_valid | output | 1 | Test answer valid |
| res_hit | output | 1 | Key possibly present |
| occ_count | output | $clog2(NPOS+1) | Number of set presence bits |
| rebuild_flag | output | 1 | Occupancy above threshold |
| underflow_err | output | 1 | Sticky removal-of-zero flag |

## Verification
A counter that drifts from its true value reaches the ports in one of two ways. It can leave a presence bit set after the last matching removal, or clear it early. Either way, the next test of an affected key shows a wrong `res_hit`, and `occ_count` is wrong as soon as the update finishes. The bench therefore compares occupancy and the error flag after every update. It also tests all 256 keys of an 8-bit configuration after each phase, so a stale or missing bit shows up before the next update. Both the counting build and the bit-only build run side by side on the same stimulus.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
   typedef enum logic [1:0] {
      OP_TEST     = 2'd0,
      OP_ADD      = 2'd1,
      OP_REMOVE   = 2'd2,
      OP_TEST_ALT = 2'd3
   } cbf_op_e;

   localparam logic [15:0] CRC_POLY  = 16'h1021;
   localparam logic [15:0] CRC_SEED  = 16'hFFFF;
   localparam logic [15:0] SEED_STEP = 16'h2F35;

   function automatic logic is_update(input logic [1:0] op);
      return (op == OP_ADD) || (op == OP_REMOVE);
   endfunction
endpackage

// File: rtl/cbf_hash.sv
module cbf_hash #(
   parameter int KEY_W = 16,
   parameter int NHASH = 3,
   parameter int IDX_W = 8
) (
   input  logic [KEY_W-1:0]            key,
   output logic [NHASH-1:0][IDX_W-1:0] pos
);
   import cbf_pkg::*;

   function automatic logic [15:0] crc_run(input logic [15:0] seed, input logic [KEY_W-1:0] k);
      logic [15:0] r;
      logic        fb;
      r = seed;
      for (int b = KEY_W - 1; b >= 0; b--) begin
         fb = r[15] ^ k[b];
         r  = {r[14:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction

   for (genvar j = 0; j < NHASH; j++) begin : g_lane
      localparam logic [15:0] SEED = CRC_SEED ^ 16'(j * SEED_STEP);
      logic [15:0] crc;
      assign crc    = crc_run(SEED, key);
      assign pos[j] = crc[IDX_W-1:0];
   end
endmodule

// File: rtl/cbf_cnt_bank.sv
module cbf_cnt_bank #(
   parameter int NPOS  = 256,
   parameter int IDX_W = 8,
   parameter int CNT_W = 3,
   parameter int CW    = (CNT_W == 0) ? 1 : CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [CW-1:0]    wdata,
   output logic [CW-1:0]    rdata
);
   if (CNT_W > 0) begin : g_store
      logic [CW-1:0] mem [NPOS];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < NPOS; i++) mem[i] <= '0;
         end else if (we) begin
            mem[idx] <= wdata;
         end
      end
      assign rdata = mem[idx];
   end else begin : g_none
      logic unused;
      assign unused = clk ^ rst_n ^ we ^ (^idx) ^ (^wdata);
      assign rdata  = '0;
   end
endmodule

// File: rtl/cbf_bitvec.sv
module cbf_bitvec #(
   parameter int NPOS  = 256,
   parameter int IDX_W = 8,
   parameter int NHASH = 3,
   parameter int OCC_W = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        set_en,
   input  logic                        clr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [NHASH-1:0][IDX_W-1:0] rd_idx,
   output logic [NHASH-1:0]            rd_bits,
   output logic                        upd_bit,
   output logic [OCC_W-1:0]            occ
);
   logic [NPOS-1:0] bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits <= '0;
         occ  <= '0;
      end else if (set_en && !bits[wr_idx]) begin
         bits[wr_idx] <= 1'b1;
         occ          <= occ + 1'b1;
      end else if (clr_en && bits[wr_idx]) begin
         bits[wr_idx] <= 1'b0;
         occ          <= occ - 1'b1;
      end
   end

   assign upd_bit = bits[wr_idx];

   for (genvar j = 0; j < NHASH; j++) begin : g_rd
      assign rd_bits[j] = bits[rd_idx[j]];
   end
endmodule

// File: rtl/cbf_ctrl.sv
module cbf_ctrl #(
   parameter int NHASH = 3,
   parameter int IDX_W = 8,
   parameter int CNT_W = 3,
   parameter int CW    = (CNT_W == 0) ? 1 : CNT_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [1:0]                  cmd_op,
   input  logic [NHASH-1:0][IDX_W-1:0] pos_in,
   input  logic [NHASH-1:0]            q_bits,
   input  logic [CW-1:0]               cur_cnt,
   input  logic                        cur_bit,
   output logic                        cmd_ready,
   output logic                        res_valid,
   output logic                        res_hit,
   output logic [IDX_W-1:0]            wr_idx,
   output logic                        cnt_we,
   output logic [CW-1:0]               cnt_wdata,
   output logic                        bit_set,
   output logic                        bit_clr,
   output logic                        underflow_err
);
   import cbf_pkg::*;

   localparam int STEP_W = (NHASH > 1) ? $clog2(NHASH) : 1;
   localparam logic [CW-1:0] MAXC = CW'((1 << CNT_W) - 1);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(NHASH - 1);

   logic                        busy;
   logic                        is_rm;
   logic [STEP_W-1:0]           step;
   logic [NHASH-1:0][IDX_W-1:0] pos_q;
   logic                        err_now;

   assign cmd_ready = !busy;
   assign wr_idx    = pos_q[step];

   always_comb begin
      cnt_we    = 1'b0;
      cnt_wdata = cur_cnt;
      bit_set   = 1'b0;
      bit_clr   = 1'b0;
      err_now   = 1'b0;
      if (busy) begin
         if (CNT_W == 0) begin
            if (!is_rm)       bit_set = !cur_bit;
            else if (cur_bit) bit_clr = 1'b1;
            else              err_now = 1'b1;
         end else if (!is_rm) begin
            if (cur_cnt != MAXC) begin
               cnt_we    = 1'b1;
               cnt_wdata = cur_cnt + 1'b1;
               bit_set   = (cur_cnt == '0);
            end
         end else begin
            if (cur_cnt == '0) begin
               err_now = 1'b1;
            end else if (cur_cnt != MAXC) begin
               cnt_we    = 1'b1;
               cnt_wdata = cur_cnt - 1'b1;
               bit_clr   = (cur_cnt == CW'(1));
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy          <= 1'b0;
         is_rm         <= 1'b0;
         step          <= '0;
         pos_q         <= '0;
         res_valid     <= 1'b0;
         res_hit       <= 1'b0;
         underflow_err <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (!busy) begin
            if (cmd_valid) begin
               if (is_update(cmd_op)) begin
                  busy  <= 1'b1;
                  is_rm <= (cmd_op == OP_REMOVE);
                  step  <= '0;
                  pos_q <= pos_in;
               end else begin
                  res_valid <= 1'b1;
                  res_hit   <= &q_bits;
               end
            end
         end else begin
            if (err_now) underflow_err <= 1'b1;
            if (step == LAST) busy <= 1'b0;
            else              step <= step + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbf_filter.sv
module cbf_filter #(
   parameter int KEY_W   = 16,
   parameter int NPOS    = 256,
   parameter int NHASH   = 3,
   parameter int CNT_W   = 3,
   parameter int OCC_PCT = 60
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   output logic                        cmd_ready,
   input  logic [1:0]                  cmd_op,
   input  logic [KEY_W-1:0]            cmd_key,
   output logic                        res_valid,
   output logic                        res_hit,
   output logic [$clog2(NPOS+1)-1:0]   occ_count,
   output logic                        rebuild_flag,
   output logic                        underflow_err
);
   localparam int IDX_W = $clog2(NPOS);
   localparam int OCC_W = $clog2(NPOS + 1);
   localparam int CW    = (CNT_W == 0) ? 1 : CNT_W;

   if ((NPOS & (NPOS - 1)) != 0 || NPOS < 2) begin : g_bad_npos
      $error("NPOS must be a power of two of at least 2");
   end
   if (IDX_W > 16) begin : g_bad_idx
      $error("table index wider than the 16-bit hash");
   end
   if (NHASH < 1) begin : g_bad_nhash
      $error("NHASH must be at least 1");
   end
   if (CNT_W < 0 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must lie in 0..8");
   end
   if (OCC_PCT < 1 || OCC_PCT > 99) begin : g_bad_pct
      $error("OCC_PCT must lie in 1..99");
   end

   logic [NHASH-1:0][IDX_W-1:0] pos;
   logic [NHASH-1:0]            q_bits;
   logic [IDX_W-1:0]            wr_idx;
   logic                        cnt_we, bit_set, bit_clr, cur_bit;
   logic [CW-1:0]               cnt_wdata, cur_cnt;

   cbf_hash #(.KEY_W(KEY_W), .NHASH(NHASH), .IDX_W(IDX_W)) u_hash (
      .key (cmd_key),
      .pos (pos)
   );

   cbf_cnt_bank #(.NPOS(NPOS), .IDX_W(IDX_W), .CNT_W(CNT_W), .CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cnt_we),
      .idx   (wr_idx),
      .wdata (cnt_wdata),
      .rdata (cur_cnt)
   );

   cbf_bitvec #(.NPOS(NPOS), .IDX_W(IDX_W), .NHASH(NHASH), .OCC_W(OCC_W)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (bit_set),
      .clr_en  (bit_clr),
      .wr_idx  (wr_idx),
      .rd_idx  (pos),
      .rd_bits (q_bits),
      .upd_bit (cur_bit),
      .occ     (occ_count)
   );

   cbf_ctrl #(.NHASH(NHASH), .IDX_W(IDX_W), .CNT_W(CNT_W), .CW(CW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_op        (cmd_op),
      .pos_in        (pos),
      .q_bits        (q_bits),
      .cur_cnt       (cur_cnt),
      .cur_bit       (cur_bit),
      .cmd_ready     (cmd_ready),
      .res_valid     (res_valid),
      .res_hit       (res_hit),
      .wr_idx        (wr_idx),
      .cnt_we        (cnt_we),
      .cnt_wdata     (cnt_wdata),
      .bit_set       (bit_set),
      .bit_clr       (bit_clr),
      .underflow_err (underflow_err)
   );

   assign rebuild_flag = (32'(occ_count) * 100) > (NPOS * OCC_PCT);
endmodule

// File: rtl/cbf_filter_chk.sv
module cbf_filter_chk #(
   parameter int NPOS  = 256,
   parameter int OCC_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [1:0]       cmd_op,
   input logic             res_valid,
   input logic [OCC_W-1:0] occ_count,
   input logic             underflow_err
);
   // R8
   accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> !cmd_ready);

   // R8
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> !res_valid);

   // R3
   result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(cmd_valid && cmd_ready && (cmd_op == 2'd0 || cmd_op == 2'd3)));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_err |=> underflow_err);

   // R9
   occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_count == $past(occ_count)) ||
      (occ_count == OCC_W'($past(occ_count) + 1'b1)) ||
      (occ_count == OCC_W'($past(occ_count) - 1'b1)));

   // R9
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ_count) <= NPOS);

   // R9
   occ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !$past(!cmd_ready)) |=> $stable(occ_count));
endmodule

bind cbf_filter cbf_filter_chk #(.NPOS(NPOS), .OCC_W(OCC_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_op        (cmd_op),
   .res_valid     (res_valid),
   .occ_count     (occ_count),
   .underflow_err (underflow_err)
);

// File: tb/tb_cbf_filter.sv
module tb_cbf_filter;
   localparam int CLK_PERIOD = 10;
   localparam int KW  = 8;
   localparam int NP  = 32;
   localparam int NH  = 3;
   localparam int CWD = 2;
   localparam int PCT = 60;
   localparam int OW  = $clog2(NP + 1);
   localparam int CMAX = (1 << CWD) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [KW-1:0] cmd_key = '0;

   logic rdy_a, rv_a, hit_a, flag_a, err_a;
   logic rdy_b, rv_b, hit_b, flag_b, err_b;
   logic [OW-1:0] occ_a, occ_b;

   int n_chk = 0;
   int n_bad = 0;

   int cnt_m [NP];
   int bit_m [NP];
   int bit0_m [NP];
   int err_m = 0;
   int err0_m = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cbf_filter #(.KEY_W(KW), .NPOS(NP), .NHASH(NH), .CNT_W(CWD), .OCC_PCT(PCT)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_a),
      .cmd_op(cmd_op), .cmd_key(cmd_key), .res_valid(rv_a), .res_hit(hit_a),
      .occ_count(occ_a), .rebuild_flag(flag_a), .underflow_err(err_a));

   cbf_filter #(.KEY_W(KW), .NPOS(NP), .NHASH(NH), .CNT_W(0), .OCC_PCT(PCT)) dut_b (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_b),
      .cmd_op(cmd_op), .cmd_key(cmd_key), .res_valid(rv_b), .res_hit(hit_b),
      .occ_count(occ_b), .rebuild_flag(flag_b), .underflow_err(err_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R2: hash position computed from the stated CRC recipe
   function automatic int hpos(input int key, input int j);
      int r;
      int fb;
      r = 'hFFFF ^ ((j * 'h2F35) & 'hFFFF);
      for (int b = KW - 1; b >= 0; b--) begin
         fb = ((r >> 15) & 1) ^ ((key >> b) & 1);
         r  = (r << 1) & 'hFFFF;
         if (fb != 0) r = r ^ 'h1021;
      end
      return r & (NP - 1);
   endfunction

   function automatic int occ_of(input int sel);
      int s = 0;
      for (int i = 0; i < NP; i++) s += (sel == 0) ? bit_m[i] : bit0_m[i];
      return s;
   endfunction

   function automatic int hit_of(input int key, input int sel);
      int h = 1;
      for (int j = 0; j < NH; j++) begin
         if (sel == 0 && bit_m[hpos(key, j)] == 0) h = 0;
         if (sel != 0 && bit0_m[hpos(key, j)] == 0) h = 0;
      end
      return h;
   endfunction

   function automatic void model_update(input bit rm, input int key);
      for (int j = 0; j < NH; j++) begin
         int p = hpos(key, j);
         if (!rm) begin
            if (cnt_m[p] < CMAX) begin
               if (cnt_m[p] == 0) bit_m[p] = 1;
               cnt_m[p]++;
            end
            bit0_m[p] = 1;
         end else begin
            if (cnt_m[p] == 0) err_m = 1;
            else if (cnt_m[p] < CMAX) begin
               cnt_m[p]--;
               if (cnt_m[p] == 0) bit_m[p] = 0;
            end
            if (bit0_m[p] != 0) bit0_m[p] = 0;
            else err0_m = 1;
         end
      end
   endfunction

   task automatic check_state(input string tag);
      int oa = occ_of(0);
      int ob = occ_of(1);
      chk(occ_a == OW'(oa), {"R9 occ ", tag}, occ_a, oa);
      chk(flag_a == (oa * 100 > NP * PCT), {"R9 flag ", tag}, flag_a, oa * 100 > NP * PCT);
      chk(err_a == err_m[0], {"R7 err ", tag}, err_a, err_m);
      chk(occ_b == OW'(ob), {"R10 occ ", tag}, occ_b, ob);
      chk(err_b == err0_m[0], {"R10 err ", tag}, err_b, err0_m);
   endtask

   task automatic do_query(input int key, input logic [1:0] op, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_key = KW'(key);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(rv_a && rv_b, {req, " res_valid"}, rv_a, 1);
      chk(hit_a == hit_of(key, 0)[0], {req, " hit"}, hit_a, hit_of(key, 0));
      chk(hit_b == hit_of(key, 1)[0], "R10 hit", hit_b, hit_of(key, 1));
   endtask

   task automatic do_update(input bit rm, input int key, input string tag);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = rm ? 2'd2 : 2'd1; cmd_key = KW'(key);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      model_update(rm, key);
      for (int i = 0; i < NH; i++) begin
         if (i > 0) @(negedge clk);
         chk(!rdy_a && !rdy_b && !rv_a, "R8 busy window", rdy_a, 0);
      end
      @(negedge clk);
      chk(rdy_a && rdy_b, "R8 ready after NHASH", rdy_a, 1);
      check_state(tag);
   endtask

   task automatic sweep(input string req);
      for (int k = 0; k < (1 << KW); k++) do_query(k, 2'd0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NP; i++) begin cnt_m[i] = 0; bit_m[i] = 0; bit0_m[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(rdy_a && rdy_b, "R1 ready", rdy_a, 1);
      chk(!rv_a && !rv_b, "R1 res_valid", rv_a, 0);
      chk(occ_a == 0 && occ_b == 0, "R1 occ", occ_a, 0);
      chk(!flag_a && !err_a && !err_b, "R1 flags", err_a, 0);
      sweep("R1");

      // R4 R2: adds, then all keys tested
      do_update(0, 'h11, "add11");
      do_update(0, 'hA5, "addA5");
      do_update(0, 'h3C, "add3C");
      sweep("R4");
      do_query('h3C, 2'd3, "R3 alt op");

      // R6: saturation keeps key present
      for (int i = 0; i < 4; i++) do_update(0, 'h77, "sat add");
      for (int i = 0; i < 4; i++) do_update(1, 'h77, "sat rm");
      do_query('h77, 2'd0, "R6");
      chk(hit_a == 1'b1, "R6 saturated key present", hit_a, 1);

      // R5: removal clears bits on 1->0
      do_update(1, 'hA5, "rmA5");
      sweep("R5");

      // R7: removal of a key hitting a zero counter
      begin
         int kz = -1;
         for (int k = 0; k < (1 << KW) && kz < 0; k++)
            for (int j = 0; j < NH; j++)
               if (kz < 0 && cnt_m[hpos(k, j)] == 0) kz = k;
         do_update(1, kz, "rm zero");
         chk(err_a == 1'b1, "R7 underflow raised", err_a, 1);
      end

      // R8: test held during update waits and sees the update
      begin
         int waited = 0;
         @(negedge clk);
         cmd_valid = 1'b1; cmd_op = 2'd1; cmd_key = KW'('h5E);
         @(posedge clk);
         @(negedge clk);
         model_update(0, 'h5E);
         cmd_op = 2'd0;
         while (!rdy_a) begin
            chk(!rv_a, "R8 no result while busy", rv_a, 0);
            waited++;
            @(negedge clk);
         end
         @(posedge clk);
         @(negedge clk);
         cmd_valid = 1'b0;
         chk(waited == NH, "R8 stall length", waited, NH);
         chk(rv_a && hit_a, "R8 stalled test hit", hit_a, 1);
      end

      // R9: fill until the rebuild flag rises
      for (int i = 0; i < 40 && occ_of(0) * 100 <= NP * PCT + 200; i++)
         do_update(0, 'h80 + i, "fill");
      chk(flag_a == 1'b1, "R9 flag reached", flag_a, 1);
      sweep("R9");

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule